// File: doc/BRIEF.md
# DMA Beat Address Generator

This block produces the byte address for each data beat of a single-channel DMA transfer. One copy drives the read side and another drives the write side of the engine. A one-cycle `load_i` pulse captures five settings: a base address, a beat granularity of 1, 2 or 4 bytes, a chunk length in bytes, a total transfer length in bytes and an addressing mode. After the load, `addr_o` holds the address of the current beat. Each cycle that `adv_i` is high while the block is running, the beat is consumed and the address moves on.

Three addressing modes are supported. Incrementing mode walks sequential memory. Fixed mode stays on one register address, such as a FIFO port. Wrap mode acts as a circular buffer: the address goes back to the base at the end of every chunk. Two combinational flags mark the beat that closes a chunk and the beat that closes the whole transfer. The final chunk may be shorter than the configured chunk length. A configuration that cannot be honoured is rejected at load time, and no beats are produced for it.

The controller has four states. `ST_IDLE` is the state after reset. `ST_RUN` is the state while beats are issued. `ST_DONE` is the state after the final beat. `ST_ERR` is the state after a rejected load. There are five transitions. A load with a valid configuration goes from any state to `ST_RUN` (LOAD_OK). A load with an invalid configuration goes from any state to `ST_ERR` (LOAD_BAD). An advance on the final beat goes from `ST_RUN` to `ST_DONE` (FINISH). Every other advance in `ST_RUN` stays in `ST_RUN` (STEP). With no load, `ST_IDLE`, `ST_DONE` and `ST_ERR` keep their state (HOLD).

Top module: `dma_addr_gen`

## Requirements
- R1: In incrementing mode (mode code 0), each accepted beat moves `addr_o` up by the granularity in bytes.
- R2: In fixed mode (mode code 1), `addr_o` equals the loaded base address for every beat of the transfer.
- R3: In wrap mode (mode code 2), the address steps up by the granularity within a chunk. After the last beat of each chunk it returns to the base address.
- R4: Granularity code 0 selects 1 byte, code 1 selects 2 bytes and code 2 selects 4 bytes. Code 3 is rejected as a configuration error.
- R5: `addr_o` changes only on a clock edge where either `load_i` is high, or `adv_i` is high and `busy_o` is high. An `adv_i` pulse in the idle, done or error state has no effect.
- R6: A load is rejected in any of these cases: the base is not aligned to the granularity, the mode code is 3, the chunk or total length is zero, or the chunk or total length is not a multiple of the granularity. When a load is rejected, `cfg_err_o` goes high, `busy_o` stays low and no beats are produced.
- R7: `last_in_chunk_o` is high, during `ST_RUN`, on the final beat of each chunk, including a shortened final chunk. `last_in_transfer_o` is high on the final beat of the transfer, and it always implies `last_in_chunk_o`.
- R8: After the final beat is accepted, `busy_o` drops and `done_o` rises one cycle later. They stay that way until the next load.
- R9: A load is accepted in any state, including in the middle of a transfer. It restarts the transfer from the new base with the beat and chunk counts cleared.
- R10: After reset, `addr_o` is 0 and `busy_o`, `done_o`, `cfg_err_o` and both last flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture the configuration and start a transfer |
| base_i | input | AW | Base byte address |
| gran_i | input | 2 | Granularity code (0: 1 B, 1: 2 B, 2: 4 B) |
| mode_i | input | 2 | Mode code (0 incrementing, 1 fixed, 2 wrap) |
| chunk_bytes_i | input | CW | Chunk length in bytes |
| total_bytes_i | input | TW | Transfer length in bytes |
| adv_i | input | 1 | Current beat accepted; advance |
| addr_o | output | AW | Byte address of the current beat |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer complete |
| cfg_err_o | output | 1 | Last load rejected |
| last_in_chunk_o | output | 1 | Current beat closes a chunk |
| last_in_transfer_o | output | 1 | Current beat closes the transfer |

## Verification
The bench targets the following corner cases:
- A wrap transfer whose total is not a multiple of the chunk. A design that wraps on the total, or that never raises the chunk flag on the short final chunk, gives the wrong address or flag on those beats.
- Each granularity code combined with each mode. A wrong step size or a wrong fixed address shows up on the second beat.
- Misaligned bases, an invalid granularity code and lengths of zero. A design that accepts any of these would go busy.
- Advance pulses given in the done and error states, and a reload in the middle of a transfer. These catch designs that keep counting after the end or that keep stale chunk counts across a restart.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

    typedef enum logic [1:0] {
        MODE_INCR  = 2'd0,
        MODE_FIXED = 2'd1,
        MODE_WRAP  = 2'd2,
        MODE_RSVD  = 2'd3
    } ag_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2,
        ST_ERR  = 2'd3
    } ag_state_e;

    // Bytes per beat for a granularity code; 0 marks an unsupported code.
    function automatic logic [2:0] gran_step(input logic [1:0] code);
        logic [2:0] s;
        unique case (code)
            2'd0:    s = 3'd1;
            2'd1:    s = 3'd2;
            2'd2:    s = 3'd4;
            default: s = 3'd0;
        endcase
        return s;
    endfunction

    // Low address bits that must be clear for a given granularity code.
    function automatic logic [1:0] gran_mask(input logic [1:0] code);
        logic [1:0] m;
        unique case (code)
            2'd0:    m = 2'b00;
            2'd1:    m = 2'b01;
            default: m = 2'b11;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dma_ag_cfg_check.sv
module dma_ag_cfg_check
    import dma_ag_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int TW = 24
) (
    input  logic [AW-1:0] base_i,
    input  logic [1:0]    gran_i,
    input  logic [1:0]    mode_i,
    input  logic [CW-1:0] chunk_i,
    input  logic [TW-1:0] total_i,
    output logic          ok_o
);
    logic [1:0] mask;
    logic       gran_ok, align_ok, mode_ok, size_ok, mult_ok;

    always_comb begin
        mask     = gran_mask(gran_i);
        gran_ok  = (gran_step(gran_i) != 3'd0);
        align_ok = ((base_i[1:0] & mask) == 2'b00);
        mode_ok  = (mode_i != MODE_RSVD);
        size_ok  = (chunk_i != '0) && (total_i != '0);
        mult_ok  = ((chunk_i[1:0] & mask) == 2'b00) && ((total_i[1:0] & mask) == 2'b00);
        ok_o     = gran_ok && align_ok && mode_ok && size_ok && mult_ok;
    end

    // R4: the reserved granularity code is never accepted
    always_comb begin
        if (gran_i == 2'd3) begin
            assert_gran_rsvd_R4: assert (!ok_o);
        end
    end
endmodule

// File: rtl/dma_ag_counter.sv
module dma_ag_counter #(
    parameter int CW = 16,
    parameter int TW = 24
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          fire_i,
    input  logic          run_i,
    input  logic [2:0]    step_i,
    input  logic [CW-1:0] chunk_i,
    input  logic [TW-1:0] total_i,
    output logic          last_chunk_o,
    output logic          last_xfer_o
);
    logic [CW-1:0] chunk_cnt_q;
    logic [TW-1:0] total_cnt_q;
    logic [CW:0]   chunk_nxt;
    logic [TW:0]   total_nxt;

    always_comb begin
        chunk_nxt    = {1'b0, chunk_cnt_q} + {{(CW-2){1'b0}}, step_i};
        total_nxt    = {1'b0, total_cnt_q} + {{(TW-2){1'b0}}, step_i};
        last_xfer_o  = (total_nxt == {1'b0, total_i});
        last_chunk_o = (chunk_nxt == {1'b0, chunk_i}) || last_xfer_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chunk_cnt_q <= '0;
            total_cnt_q <= '0;
        end else if (clr_i) begin
            chunk_cnt_q <= '0;
            total_cnt_q <= '0;
        end else if (fire_i) begin
            total_cnt_q <= total_nxt[TW-1:0];
            chunk_cnt_q <= last_chunk_o ? '0 : chunk_nxt[CW-1:0];
        end
    end

    // R7: the in-chunk count stays below the chunk length while running
    assert_chunk_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (chunk_cnt_q < chunk_i));

    // R7: the transfer count stays below the total while running
    assert_total_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (total_cnt_q < total_i));
endmodule

// File: rtl/dma_ag_addr_step.sv
module dma_ag_addr_step
    import dma_ag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [AW-1:0] load_base_i,
    input  logic          fire_i,
    input  logic [2:0]    step_i,
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] base_i,
    input  logic          last_chunk_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] addr_q, addr_d, addr_inc;

    always_comb begin
        addr_inc = addr_q + {{(AW-3){1'b0}}, step_i};
        addr_d   = addr_q;
        if (load_i) begin
            addr_d = load_base_i;
        end else if (fire_i) begin
            unique case (mode_i)
                MODE_INCR:  addr_d = addr_inc;
                MODE_FIXED: addr_d = base_i;
                MODE_WRAP:  addr_d = last_chunk_i ? base_i : addr_inc;
                default:    addr_d = addr_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) addr_q <= '0;
        else         addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    // R5: the address holds when there is neither a load nor an accepted beat
    assert_addr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !fire_i) |=> $stable(addr_o));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int TW = 24
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic [1:0]    gran_i,
    input  logic [1:0]    mode_i,
    input  logic [CW-1:0] chunk_bytes_i,
    input  logic [TW-1:0] total_bytes_i,
    input  logic          adv_i,
    output logic [AW-1:0] addr_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          cfg_err_o,
    output logic          last_in_chunk_o,
    output logic          last_in_transfer_o
);
    ag_state_e     state_q, state_d;
    logic [AW-1:0] base_q;
    logic [1:0]    gran_q, mode_q;
    logic [CW-1:0] chunk_q;
    logic [TW-1:0] total_q;
    logic [2:0]    step;
    logic          cfg_ok, fire, run, last_chunk, last_xfer;

    dma_ag_cfg_check #(.AW(AW), .CW(CW), .TW(TW)) u_cfg (
        .base_i  (base_i),
        .gran_i  (gran_i),
        .mode_i  (mode_i),
        .chunk_i (chunk_bytes_i),
        .total_i (total_bytes_i),
        .ok_o    (cfg_ok)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            base_q  <= '0;
            gran_q  <= '0;
            mode_q  <= '0;
            chunk_q <= '0;
            total_q <= '0;
        end else if (load_i) begin
            base_q  <= base_i;
            gran_q  <= gran_i;
            mode_q  <= mode_i;
            chunk_q <= chunk_bytes_i;
            total_q <= total_bytes_i;
        end
    end

    assign step = gran_step(gran_q);
    assign run  = (state_q == ST_RUN);
    assign fire = adv_i && run && !load_i;

    dma_ag_counter #(.CW(CW), .TW(TW)) u_cnt (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .clr_i        (load_i),
        .fire_i       (fire),
        .run_i        (run),
        .step_i       (step),
        .chunk_i      (chunk_q),
        .total_i      (total_q),
        .last_chunk_o (last_chunk),
        .last_xfer_o  (last_xfer)
    );

    dma_ag_addr_step #(.AW(AW)) u_addr (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .load_i       (load_i),
        .load_base_i  (base_i),
        .fire_i       (fire),
        .step_i       (step),
        .mode_i       (mode_q),
        .base_i       (base_q),
        .last_chunk_i (last_chunk),
        .addr_o       (addr_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = cfg_ok ? ST_RUN : ST_ERR;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN:  state_d = (fire && last_xfer) ? ST_DONE : ST_RUN;
                ST_DONE: state_d = ST_DONE;
                ST_ERR:  state_d = ST_ERR;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy_o             = 1'b0;
        done_o             = 1'b0;
        cfg_err_o          = 1'b0;
        last_in_chunk_o    = 1'b0;
        last_in_transfer_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                busy_o             = 1'b1;
                last_in_chunk_o    = last_chunk;
                last_in_transfer_o = last_xfer;
            end
            ST_DONE: done_o    = 1'b1;
            ST_ERR:  cfg_err_o = 1'b1;
            default: ;
        endcase
    end

    // R1: incrementing beats step by the granularity
    assert_incr_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire && mode_q == MODE_INCR) |=> (addr_o == $past(addr_o) + {{(AW-3){1'b0}}, $past(step)}));

    // R2: fixed mode never leaves the base
    assert_fixed_base_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && mode_q == MODE_FIXED) |-> (addr_o == base_q));

    // R3: wrap mode returns to the base after a chunk closes
    assert_wrap_return_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire && mode_q == MODE_WRAP && last_in_chunk_o && !last_in_transfer_o) |=> (addr_o == base_q));

    // R6: an error and a running transfer never coexist
    assert_err_not_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> (!busy_o && !done_o));

    // R7: the transfer end is always also a chunk end
    assert_last_nesting_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_in_transfer_o |-> last_in_chunk_o);

    // R8: the final accepted beat leads to done
    assert_finish_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire && last_in_transfer_o) |=> (done_o && !busy_o));
endmodule

// File: tb/dma_addr_gen_bench.sv
module dma_addr_gen_bench;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int TW = 24;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          load_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [1:0]    gran_i = '0;
    logic [1:0]    mode_i = '0;
    logic [CW-1:0] chunk_bytes_i = '0;
    logic [TW-1:0] total_bytes_i = '0;
    logic          adv_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic          busy_o, done_o, cfg_err_o, last_in_chunk_o, last_in_transfer_o;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk_i = ~clk_i;

    dma_addr_gen #(.AW(AW), .CW(CW), .TW(TW)) u_dma_addr_gen (
        .clk_i, .rst_ni, .load_i, .base_i, .gran_i, .mode_i,
        .chunk_bytes_i, .total_bytes_i, .adv_i, .addr_o, .busy_o,
        .done_o, .cfg_err_o, .last_in_chunk_o, .last_in_transfer_o
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drives a one-cycle load; called and returns at a negedge.
    task automatic do_load(input logic [AW-1:0] b, input logic [1:0] g, input logic [1:0] m,
                           input int ch, input int tot);
        base_i = b; gran_i = g; mode_i = m;
        chunk_bytes_i = CW'(ch); total_bytes_i = TW'(tot);
        load_i = 1'b1;
        @(negedge clk_i);
        load_i = 1'b0;
    endtask

    // Full transfer with a reference walk computed from the requirements.
    task automatic run_xfer(input string req, input logic [AW-1:0] b, input logic [1:0] g,
                            input logic [1:0] m, input int ch, input int tot);
        int step;
        int beats;
        logic [AW-1:0] exp_addr;
        logic [AW-1:0] held;
        step  = (g == 2'd0) ? 1 : (g == 2'd1) ? 2 : 4;
        beats = tot / step;
        do_load(b, g, m, ch, tot);
        for (int k = 0; k < beats; k++) begin
            if (m == 2'd0)      exp_addr = b + AW'(k * step);
            else if (m == 2'd1) exp_addr = b;
            else                exp_addr = b + AW'((k * step) % ch);
            check({req, " addr"}, 64'(addr_o), 64'(exp_addr));
            check("R7 last_in_chunk", 64'(last_in_chunk_o),
                  64'((((k + 1) * step) % ch == 0) || ((k + 1) * step == tot)));
            check("R7 last_in_transfer", 64'(last_in_transfer_o), 64'((k + 1) * step == tot));
            adv_i = 1'b1;
            @(negedge clk_i);
            adv_i = 1'b0;
        end
        check("R8 done", 64'(done_o), 64'd1);
        check("R8 busy", 64'(busy_o), 64'd0);
        held = addr_o;
        adv_i = 1'b1;
        repeat (2) @(negedge clk_i);
        adv_i = 1'b0;
        check("R5 addr after done", 64'(addr_o), 64'(held));
        check("R8 done held", 64'(done_o), 64'd1);
    endtask

    task automatic t_reset();
        check("R10 addr", 64'(addr_o), 64'd0);
        check("R10 busy", 64'(busy_o), 64'd0);
        check("R10 done", 64'(done_o), 64'd0);
        check("R10 err", 64'(cfg_err_o), 64'd0);
        check("R10 lasts", 64'({last_in_chunk_o, last_in_transfer_o}), 64'd0);
        adv_i = 1'b1;
        @(negedge clk_i);
        adv_i = 1'b0;
        check("R5 adv in idle", 64'({busy_o, addr_o}), 64'd0);
    endtask

    task automatic t_bad(input string req, input logic [AW-1:0] b, input logic [1:0] g,
                         input logic [1:0] m, input int ch, input int tot);
        logic [AW-1:0] held;
        do_load(b, g, m, ch, tot);
        check({req, " cfg_err"}, 64'(cfg_err_o), 64'd1);
        check({req, " busy"}, 64'(busy_o), 64'd0);
        held = addr_o;
        adv_i = 1'b1;
        @(negedge clk_i);
        adv_i = 1'b0;
        check("R5 adv in error", 64'({busy_o, addr_o}), 64'({1'b0, held}));
    endtask

    task automatic t_restart();
        // R9: start a wrap transfer, take 3 beats, then reload mid-chunk
        do_load(32'h100, 2'd2, 2'd2, 16, 64);
        adv_i = 1'b1;
        repeat (3) @(negedge clk_i);
        adv_i = 1'b0;
        check("R9 mid addr", 64'(addr_o), 64'h10C);
        do_load(32'h800, 2'd2, 2'd2, 8, 16);
        check("R9 restart addr", 64'(addr_o), 64'h800);
        check("R9 no early last", 64'(last_in_chunk_o), 64'd0);
        adv_i = 1'b1;
        @(negedge clk_i);
        adv_i = 1'b0;
        check("R9 chunk end", 64'(last_in_chunk_o), 64'd1);
        check("R9 addr", 64'(addr_o), 64'h804);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        run_xfer("R1 incr 4B", 32'h1000, 2'd2, 2'd0, 16, 40);
        run_xfer("R1 incr 1B", 32'h2003, 2'd0, 2'd0, 4, 7);
        run_xfer("R2 fixed 2B", 32'h3002, 2'd1, 2'd1, 6, 14);
        run_xfer("R3 wrap 1B short tail", 32'h4001, 2'd0, 2'd2, 4, 10);
        run_xfer("R3 wrap 4B", 32'h5000, 2'd2, 2'd2, 12, 28);
        run_xfer("R4 gran 2B", 32'h6002, 2'd1, 2'd0, 8, 8);
        t_bad("R4 gran code 3", 32'h7000, 2'd3, 2'd0, 8, 8);
        t_bad("R6 misaligned", 32'h7002, 2'd2, 2'd0, 8, 8);
        t_bad("R6 mode 3", 32'h7000, 2'd0, 2'd3, 8, 8);
        t_bad("R6 zero chunk", 32'h7000, 2'd0, 2'd0, 0, 8);
        t_bad("R6 zero total", 32'h7000, 2'd0, 2'd0, 8, 0);
        t_bad("R6 total not multiple", 32'h7000, 2'd1, 2'd0, 8, 7);
        t_restart();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule